// File: doc/BRIEF.md
# Address Register Effective Address Unit

This block keeps a bank of general-purpose address registers and turns each memory-operand request into an effective address. A request names a register, an addressing mode, an operand size and a 32-bit extension value. The block forms the address, registers it, and truncates it to the width of the external address bus. For the auto-increment and auto-decrement modes it also writes the stepped value back into the selected register and reports that update on a write-back port. The address and the write-back both appear on the clock edge that samples the request.

A separate load port writes a full register value from an outside data path. It is used to set pointers before they are used. The highest-numbered register acts as the stack pointer. When that register takes a byte-sized step, the step is widened to keep the stack aligned to the word size.

Top module: `ea_addr_unit`

## Requirements
- R1: Reset (rst_n low) clears every address register to zero and drives ea_valid=0, wb_valid=0 and ea_out=0.
- R2: Mode code 0 (indirect) gives ea_out = low 24 bits of the selected register and leaves the register unchanged (wb_valid=0).
- R3: Mode code 1 (post-increment) gives ea_out = the old register value, then stores old+step into the register, with wb_valid=1, wb_idx=reg_sel and wb_val=the new value.
- R4: Mode code 2 (pre-decrement) stores old-step into the register and gives ea_out = that new value, with wb_valid=1, wb_idx=reg_sel and wb_val=the new value.
- R5: The step is 1 for size code 0 (byte), 2 for size code 1 (word) and 4 for size code 2 (long); size code 3 is treated as long.
- R6: A byte-sized post-increment or pre-decrement on register 7 (the stack pointer) steps by 2.
- R7: Mode code 3 (displacement) gives ea_out = register + ext[15:0] sign-extended, and does not change the register.
- R8: Mode code 4 (absolute short) gives ea_out = ext[15:0] sign-extended. Mode code 5 (absolute long) gives ea_out = ext[31:0]. Neither mode reads or changes a register.
- R9: Registers and address sums wrap at 32 bits, and ea_out carries only bits 23:0 of the address.
- R10: When req is low, no register changes, ea_valid and wb_valid are 0 on the next cycle, and ea_out holds its previous value.
- R11: When ld_en is high, ld_data is written into register ld_sel at the clock edge. If the same register is also the target of a write-back in that cycle, the load wins and wb_valid stays 0.
- R12: Mode codes 6 and 7 are reserved. They give ea_valid=0 and wb_valid=0, and they change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Request strobe, sampled on the rising edge |
| mode | input | 3 | Addressing mode code |
| reg_sel | input | 3 | Address register index |
| size | input | 2 | Operand size code |
| ext | input | 32 | Extension value: displacement or absolute address |
| ld_en | input | 1 | Register load enable |
| ld_sel | input | 3 | Register index for a load |
| ld_data | input | 32 | Value to load |
| ea_valid | output | 1 | ea_out was produced by the last accepted request |
| ea_out | output | 24 | Effective address on the external bus |
| wb_valid | output | 1 | A register was updated by the last request |
| wb_idx | output | 3 | Index of the updated register |
| wb_val | output | 32 | New 32-bit register value |

## Verification
The main function is driven by a sequence of requests. Each request changes the register state that the next one sees. Byte, word and long steps alternate on the same pointer, so a wrong step size or a wrong increment order puts every later address off by a visible amount. Address, stack-pointer and mode patterns are chosen to separate cases that are easy to confuse: stack-pointer and ordinary-register byte steps, positive and negative displacements, and short absolute words with the top bit set and clear. Pointers near 2^24 and 2^32 expose truncation and wrap errors. Directed cases cover idle cycles, reserved modes, a load that collides with a write-back, and a reset issued in the middle of a run. Register state after each of these is read back through indirect requests.

// File: rtl/ea_pkg.sv
// Package: shared encodings for the effective-address unit.
// Assumes a 3-bit mode field and a 2-bit size field on the request.
package ea_pkg;

    localparam int MODE_W = 3;
    localparam int SIZE_W = 2;

    typedef enum logic [MODE_W-1:0] {
        AM_IND  = 3'd0,
        AM_POST = 3'd1,
        AM_PRE  = 3'd2,
        AM_DISP = 3'd3,
        AM_ABSW = 3'd4,
        AM_ABSL = 3'd5,
        AM_RSV6 = 3'd6,
        AM_RSV7 = 3'd7
    } amode_e;

    typedef enum logic [SIZE_W-1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_RSV  = 2'd3
    } osize_e;

endpackage

// File: rtl/ea_step.sv
// Module: step size for auto-increment and auto-decrement.
// Assumes the stack-pointer index is fixed by parameter; byte steps on it widen to 2.
module ea_step #(
    parameter int AW     = 32,
    parameter int SEL_W  = 3,
    parameter int SP_IDX = 7
) (
    input  logic [ea_pkg::SIZE_W-1:0] size,
    input  logic [SEL_W-1:0]          sel,
    output logic [AW-1:0]             step
);
    import ea_pkg::*;

    logic is_sp;
    assign is_sp = (sel == SEL_W'(SP_IDX));

    // Map the operand size (and stack-pointer case) to a step.
    always_comb begin
        case (osize_e'(size))
            SZ_BYTE: step = is_sp ? AW'(2) : AW'(1);
            SZ_WORD: step = AW'(2);
            default: step = AW'(4);
        endcase
    end
endmodule

// File: rtl/ea_calc.sv
// Module: combinational address and new-register-value generator.
// Assumes base is the selected register's current value; no state.
module ea_calc #(
    parameter int AW    = 32,
    parameter int DISP_W = 16
) (
    input  logic [ea_pkg::MODE_W-1:0] mode,
    input  logic [AW-1:0]             base,
    input  logic [AW-1:0]             step,
    input  logic [AW-1:0]             ext,
    output logic [AW-1:0]             addr,
    output logic [AW-1:0]             new_val,
    output logic                      do_wb,
    output logic                      ok
);
    import ea_pkg::*;

    logic [AW-1:0] ext_sx;
    assign ext_sx = {{(AW-DISP_W){ext[DISP_W-1]}}, ext[DISP_W-1:0]};

    // Select address source and side effect by addressing mode.
    always_comb begin
        addr    = base;
        new_val = base;
        do_wb   = 1'b0;
        ok      = 1'b1;
        case (amode_e'(mode))
            AM_IND:  addr = base;
            AM_POST: begin
                addr    = base;
                new_val = base + step;
                do_wb   = 1'b1;
            end
            AM_PRE: begin
                new_val = base - step;
                addr    = base - step;
                do_wb   = 1'b1;
            end
            AM_DISP: addr = base + ext_sx;
            AM_ABSW: addr = ext_sx;
            AM_ABSL: addr = ext;
            default: begin
                ok   = 1'b0;
                addr = base;
            end
        endcase
    end
endmodule

// File: rtl/ea_regfile.sv
// Module: address register bank, one read port, write-back and load ports.
// Assumes a load takes priority over a write-back to the same register.
module ea_regfile #(
    parameter int NREGS = 8,
    parameter int AW    = 32,
    localparam int SEL_W = $clog2(NREGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] rd_sel,
    output logic [AW-1:0]    rd_data,
    input  logic             wb_en,
    input  logic [SEL_W-1:0] wb_sel,
    input  logic [AW-1:0]    wb_data,
    input  logic             ld_en,
    input  logic [SEL_W-1:0] ld_sel,
    input  logic [AW-1:0]    ld_data
);
    logic [AW-1:0] regs [NREGS];

    assign rd_data = regs[rd_sel];

    // Update each register from the load or write-back port.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NREGS; i++) begin
            if (!rst_n) begin
                regs[i] <= '0;
            end else if (ld_en && ld_sel == SEL_W'(i)) begin
                regs[i] <= ld_data;
            end else if (wb_en && wb_sel == SEL_W'(i)) begin
                regs[i] <= wb_data;
            end
        end
    end
endmodule

// File: rtl/ea_addr_unit.sv
// Module: top of the effective-address unit.
// Computes the address for each request, updates the register for the
// auto-step modes and registers the bus address and write-back report.
// Assumes request fields are stable around the sampling edge.
module ea_addr_unit #(
    parameter int NREGS  = 8,
    parameter int AW     = 32,
    parameter int BUS_W  = 24,
    parameter int SP_IDX = 7,
    localparam int SEL_W = $clog2(NREGS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req,
    input  logic [ea_pkg::MODE_W-1:0] mode,
    input  logic [SEL_W-1:0]          reg_sel,
    input  logic [ea_pkg::SIZE_W-1:0] size,
    input  logic [AW-1:0]             ext,
    input  logic                      ld_en,
    input  logic [SEL_W-1:0]          ld_sel,
    input  logic [AW-1:0]             ld_data,
    output logic                      ea_valid,
    output logic [BUS_W-1:0]          ea_out,
    output logic                      wb_valid,
    output logic [SEL_W-1:0]          wb_idx,
    output logic [AW-1:0]             wb_val
);
    logic [AW-1:0] base, step, addr, new_val;
    logic          do_wb, ok, wb_fire, collide;

    ea_regfile #(.NREGS(NREGS), .AW(AW)) u_rf (
        .clk(clk), .rst_n(rst_n),
        .rd_sel(reg_sel), .rd_data(base),
        .wb_en(wb_fire), .wb_sel(reg_sel), .wb_data(new_val),
        .ld_en(ld_en), .ld_sel(ld_sel), .ld_data(ld_data)
    );

    ea_step #(.AW(AW), .SEL_W(SEL_W), .SP_IDX(SP_IDX)) u_step (
        .size(size), .sel(reg_sel), .step(step)
    );

    ea_calc #(.AW(AW), .DISP_W(16)) u_calc (
        .mode(mode), .base(base), .step(step), .ext(ext),
        .addr(addr), .new_val(new_val), .do_wb(do_wb), .ok(ok)
    );

    assign collide = ld_en && (ld_sel == reg_sel);
    assign wb_fire = req && do_wb && !collide;

    // Register the bus address and write-back report for each request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ea_valid <= 1'b0;
            ea_out   <= '0;
            wb_valid <= 1'b0;
            wb_idx   <= '0;
            wb_val   <= '0;
        end else begin
            ea_valid <= req && ok;
            wb_valid <= wb_fire;
            if (req && ok) ea_out <= addr[BUS_W-1:0];
            if (wb_fire) begin
                wb_idx <= reg_sel;
                wb_val <= new_val;
            end
        end
    end
endmodule

// File: rtl/ea_addr_unit_chk.sv
// Module: protocol checker for ea_addr_unit, attached by bind.
// Assumes the default 3-bit register index and 24-bit bus.
module ea_addr_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req,
    input logic [2:0]  mode,
    input logic [2:0]  reg_sel,
    input logic [1:0]  size,
    input logic [31:0] ext,
    input logic        ld_en,
    input logic [2:0]  ld_sel,
    input logic        ea_valid,
    input logic [23:0] ea_out,
    input logic        wb_valid,
    input logic [2:0]  wb_idx,
    input logic [31:0] wb_val
);
    logic       clash;
    logic [7:0] exp_step;
    assign clash    = ld_en && (ld_sel == reg_sel);
    assign exp_step = (size == 2'd0) ? ((reg_sel == 3'd7) ? 8'd2 : 8'd1)
                    : (size == 2'd1) ? 8'd2 : 8'd4;

    a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> (!ea_valid && !wb_valid && $stable(ea_out)));

    a_r2_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
        (req && mode == 3'd0) |=> (ea_valid && !wb_valid));

    a_r3_post_step: assert property (@(posedge clk) disable iff (!rst_n)
        (req && mode == 3'd1 && !clash) |=>
            (wb_valid && (wb_val[23:0] - ea_out) == 24'($past(exp_step))));

    a_r4_pre_match: assert property (@(posedge clk) disable iff (!rst_n)
        (req && mode == 3'd2 && !clash) |=> (wb_valid && wb_val[23:0] == ea_out));

    a_r7_disp_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (req && mode == 3'd3) |=> (ea_valid && !wb_valid));

    a_r8_abs_long: assert property (@(posedge clk) disable iff (!rst_n)
        (req && mode == 3'd5) |=> (ea_out == $past(ext[23:0]) && !wb_valid));

    a_r11_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (req && clash) |=> !wb_valid);

    a_r12_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        (req && mode[2:1] == 2'b11) |=> (!ea_valid && !wb_valid));

    a_r3_wb_index: assert property (@(posedge clk) disable iff (!rst_n)
        (req && (mode == 3'd1 || mode == 3'd2) && !clash) |=> (wb_idx == $past(reg_sel)));
endmodule

bind ea_addr_unit ea_addr_unit_chk u_chk (
    .clk(clk), .rst_n(rst_n), .req(req), .mode(mode), .reg_sel(reg_sel),
    .size(size), .ext(ext), .ld_en(ld_en), .ld_sel(ld_sel),
    .ea_valid(ea_valid), .ea_out(ea_out), .wb_valid(wb_valid),
    .wb_idx(wb_idx), .wb_val(wb_val)
);

// File: tb/tb_ea_addr_unit.sv
module tb_ea_addr_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [2:0]  mode = '0;
    logic [2:0]  reg_sel = '0;
    logic [1:0]  size = '0;
    logic [31:0] ext = '0;
    logic        ld_en = 1'b0;
    logic [2:0]  ld_sel = '0;
    logic [31:0] ld_data = '0;
    logic        ea_valid, wb_valid;
    logic [23:0] ea_out;
    logic [2:0]  wb_idx;
    logic [31:0] wb_val;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    ea_addr_unit dut (
        .clk(clk), .rst_n(rst_n), .req(req), .mode(mode), .reg_sel(reg_sel),
        .size(size), .ext(ext), .ld_en(ld_en), .ld_sel(ld_sel), .ld_data(ld_data),
        .ea_valid(ea_valid), .ea_out(ea_out), .wb_valid(wb_valid),
        .wb_idx(wb_idx), .wb_val(wb_val)
    );

    typedef struct packed {
        logic [2:0]  m;
        logic [2:0]  r;
        logic [1:0]  s;
        logic [31:0] x;
        logic        w;
        logic [31:0] wv;
        logic [23:0] ea;
    } vec_t;

    // Sequential vectors; each row sees the register state left by the one above.
    localparam vec_t TBL [20] = '{
        '{3'd0, 3'd0, 2'd2, 32'h0,        1'b0, 32'h0,        24'h001000}, // R2
        '{3'd1, 3'd0, 2'd0, 32'h0,        1'b1, 32'h00001001, 24'h001000}, // R3 R5 byte
        '{3'd1, 3'd0, 2'd1, 32'h0,        1'b1, 32'h00001003, 24'h001001}, // R3 R5 word
        '{3'd1, 3'd0, 2'd2, 32'h0,        1'b1, 32'h00001007, 24'h001003}, // R3 R5 long
        '{3'd2, 3'd0, 2'd2, 32'h0,        1'b1, 32'h00001003, 24'h001003}, // R4
        '{3'd2, 3'd0, 2'd1, 32'h0,        1'b1, 32'h00001001, 24'h001001}, // R4
        '{3'd2, 3'd0, 2'd0, 32'h0,        1'b1, 32'h00001000, 24'h001000}, // R4
        '{3'd1, 3'd7, 2'd0, 32'h0,        1'b1, 32'h00002002, 24'h002000}, // R6
        '{3'd2, 3'd7, 2'd0, 32'h0,        1'b1, 32'h00002000, 24'h002000}, // R6
        '{3'd2, 3'd7, 2'd1, 32'h0,        1'b1, 32'h00001FFE, 24'h001FFE}, // R4
        '{3'd3, 3'd0, 2'd1, 32'h00000010, 1'b0, 32'h0,        24'h001010}, // R7
        '{3'd3, 3'd0, 2'd1, 32'h0000FFF0, 1'b0, 32'h0,        24'h000FF0}, // R7 negative
        '{3'd3, 3'd1, 2'd1, 32'h00000004, 1'b0, 32'h0,        24'h000002}, // R7 R9
        '{3'd4, 3'd0, 2'd1, 32'h00008000, 1'b0, 32'h0,        24'hFF8000}, // R8 short neg
        '{3'd4, 3'd0, 2'd1, 32'h00007FFE, 1'b0, 32'h0,        24'h007FFE}, // R8 short pos
        '{3'd5, 3'd0, 2'd2, 32'hAB123456, 1'b0, 32'h0,        24'h123456}, // R8 long
        '{3'd2, 3'd2, 2'd2, 32'h0,        1'b1, 32'hFFFFFFFC, 24'hFFFFFC}, // R9 wrap
        '{3'd1, 3'd3, 2'd0, 32'h0,        1'b1, 32'h01000000, 24'hFFFFFF}, // R9
        '{3'd0, 3'd3, 2'd2, 32'h0,        1'b0, 32'h0,        24'h000000}, // R9 truncate
        '{3'd1, 3'd1, 2'd3, 32'h0,        1'b1, 32'h13000002, 24'hFFFFFE}  // R5 code 3
    };

    task automatic check(input bit ok, input string rq, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] m, input logic [2:0] r,
                         input logic [1:0] s, input logic [31:0] x);
        @(negedge clk);
        req = 1'b1; mode = m; reg_sel = r; size = s; ext = x;
        @(posedge clk);
        #1;
        @(negedge clk);
        req = 1'b0;
    endtask

    task automatic load(input logic [2:0] r, input logic [31:0] d);
        @(negedge clk);
        ld_en = 1'b1; ld_sel = r; ld_data = d;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic peek(input logic [2:0] r, input logic [23:0] exp, input string rq);
        issue(3'd0, r, 2'd2, 32'h0);
        check(ea_valid && ea_out == exp, rq, {8'h0, ea_out}, {8'h0, exp});
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(!ea_valid && !wb_valid && ea_out == 24'h0, "R1 reset outputs",
              {8'h0, ea_out}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 8; i++) peek(3'(i), 24'h0, "R1 register cleared");

        load(3'd0, 32'h00001000);
        load(3'd1, 32'h12FFFFFE);
        load(3'd2, 32'h00000000);
        load(3'd3, 32'h00FFFFFF);
        load(3'd7, 32'h00002000);
        peek(3'd1, 24'hFFFFFE, "R11 load");

        for (int i = 0; i < 20; i++) begin
            vec_t v;
            v = TBL[i];
            @(negedge clk);
            req = 1'b1; mode = v.m; reg_sel = v.r; size = v.s; ext = v.x;
            @(posedge clk);
            #1;
            check(ea_valid && ea_out == v.ea, "R2-R9 vector ea",
                  {8'h0, ea_out}, {8'h0, v.ea});
            check(wb_valid == v.w, "R2 R3 R4 wb_valid", 32'(wb_valid), 32'(v.w));
            if (v.w)
                check(wb_val == v.wv && wb_idx == v.r, "R3 R4 write-back",
                      wb_val, v.wv);
        end
        @(negedge clk);
        req = 1'b0;

        // R10: idle cycle holds the address and changes nothing
        @(posedge clk);
        #1;
        check(!ea_valid && !wb_valid && ea_out == 24'hFFFFFE, "R10 idle",
              {8'h0, ea_out}, 32'h00FFFFFE);
        peek(3'd1, 24'h000002, "R10 register kept");

        // R12: reserved modes
        issue(3'd6, 3'd0, 2'd2, 32'h0);
        check(!ea_valid && !wb_valid, "R12 mode 6", {30'h0, ea_valid, wb_valid}, 32'h0);
        issue(3'd7, 3'd0, 2'd0, 32'h0);
        check(!ea_valid && !wb_valid, "R12 mode 7", {30'h0, ea_valid, wb_valid}, 32'h0);
        peek(3'd0, 24'h001000, "R12 register kept");

        // R7/R8: displacement and absolute leave the register alone
        peek(3'd7, 24'h001FFE, "R7 R8 stack pointer kept");

        // R11: load collides with a post-increment write-back
        @(negedge clk);
        req = 1'b1; mode = 3'd1; reg_sel = 3'd0; size = 2'd2; ext = '0;
        ld_en = 1'b1; ld_sel = 3'd0; ld_data = 32'h00005555;
        @(posedge clk);
        #1;
        check(ea_valid && ea_out == 24'h001000, "R11 collide ea",
              {8'h0, ea_out}, 32'h00001000);
        check(!wb_valid, "R11 collide no wb", 32'(wb_valid), 32'h0);
        @(negedge clk);
        req = 1'b0; ld_en = 1'b0;
        peek(3'd0, 24'h005555, "R11 load wins");

        // R11: load to another register alongside a write-back
        @(negedge clk);
        req = 1'b1; mode = 3'd2; reg_sel = 3'd0; size = 2'd1; ext = '0;
        ld_en = 1'b1; ld_sel = 3'd4; ld_data = 32'h00ABCDEF;
        @(posedge clk);
        #1;
        check(wb_valid && wb_val == 32'h00005553, "R11 independent wb",
              wb_val, 32'h00005553);
        @(negedge clk);
        req = 1'b0; ld_en = 1'b0;
        peek(3'd4, 24'hABCDEF, "R11 independent load");

        // R1: reset in mid-run clears registers
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check(!ea_valid && !wb_valid && ea_out == 24'h0, "R1 mid-run reset",
              {8'h0, ea_out}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        peek(3'd7, 24'h0, "R1 stack pointer cleared");
        peek(3'd4, 24'h0, "R1 register cleared");

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule